// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits between the receive side of an Ethernet MAC and the engine that writes received frames into memory. Bytes of each frame arrive one per cycle with start and end markers. With the last byte comes a flag, computed upstream, that says whether the CRC matched. The filter holds the whole frame in an internal byte store until the end marker arrives. It then decides whether to keep or discard the frame. A kept frame is replayed on the output. A discarded frame leaves no trace on the output.

A kept frame can have its trailing four FCS bytes removed. It can also be preceded by zero to three zero-valued pad bytes, so that the payload lands at a chosen byte offset inside the first receive buffer. A pad flag on each output byte marks these bytes. The filter checks the length/type field against the measured payload length. Fields that carry a type identifier are exempt from this check. A CRC-ignore mode lets frames with a bad CRC through without counting them. Separate saturating counters record length errors and FCS errors.

Top module: `rx_frame_filter`

## Requirements
- R1: After a synchronous reset, `out_valid`, `frame_commit` and `frame_drop` are low and both error counters read zero.
- R2: One cycle after the byte marked `in_eof`, exactly one of `frame_commit` or `frame_drop` pulses for one cycle. A committed frame's bytes appear on the output in arrival order, one per cycle with no gaps, with `out_sof` on the first output byte and `out_eof` on the last. A dropped frame produces no output byte.
- R3: `cfg_offset` is captured at the end-of-frame byte, and its value N (binary 00..11 meaning 0..3) places N bytes before the first frame byte. Each of these bytes has `out_data` = 0 and `out_pad` = 1. Frame bytes have `out_pad` = 0.
- R4: The length/type field is frame bytes 13 and 14, counting from 1 at the first destination-address byte, most significant byte first. The measured length is the total byte count minus 18 (the 14-byte header and the 4-byte FCS), or 0 when the frame has fewer than 18 bytes. With `cfg_len_chk` = 1, a frame of at least 14 bytes whose field is below 0x0600 and larger than the measured length is dropped, and `len_err_cnt` increments.
- R5: A length/type field of 0x0600 or more is a type identifier and never causes a length error, even with `cfg_len_chk` = 1.
- R6: With `cfg_len_chk` = 0, no frame is dropped for its length and `len_err_cnt` does not change.
- R7: With `cfg_strip_fcs` = 1, the last four bytes of a kept frame are not output. With `cfg_strip_fcs` = 0, every byte is output.
- R8: With `cfg_ign_fcs` = 0, a frame whose `in_crc_ok` is low at its end byte is dropped, and `fcs_err_cnt` increments.
- R9: With `cfg_ign_fcs` = 1, a frame with `in_crc_ok` low is not dropped for that reason, and `fcs_err_cnt` does not change.
- R10: Each error counter stops at its all-ones value. An error that occurs at all-ones leaves the counter unchanged.
- R11: A frame that would output no frame bytes is dropped. This is the case for a frame of four bytes or fewer with `cfg_strip_fcs` = 1. Such a frame changes the counters only through R4 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_offset | input | 2 | Number of leading pad bytes, 0..3 |
| cfg_len_chk | input | 1 | Enable the length/type check |
| cfg_strip_fcs | input | 1 | Remove the last four bytes of each kept frame |
| cfg_ign_fcs | input | 1 | Accept frames with a bad CRC and do not count them |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_ok | input | 1 | CRC matched; sampled with the end byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte (zero for pad bytes) |
| out_pad | output | 1 | Output byte is alignment padding |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| frame_commit | output | 1 | Pulse: frame accepted |
| frame_drop | output | 1 | Pulse: frame discarded |
| len_err_cnt | output | CNT_W | Saturating length-error count |
| fcs_err_cnt | output | CNT_W | Saturating FCS-error count |

## Verification
A corrupted write or rewind pointer shows up within the next kept frame. It appears as stale or shifted bytes, or as leftover bytes from a discarded frame appearing in the output. A wrong decision shows up at once as a commit where a drop was due, or the reverse, one cycle after the end byte, together with a counter that moves when it should not. A wrong emitter count shows in the output sequence two cycles after it starts, as a wrong number of pad bytes, a missing FCS cut, or a misplaced start or end marker. The sweeps cross offset, stripping and length around the header, FCS and 0x0600 boundaries, so each of these faults changes the captured output stream or a counter value.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int HDR_BYTES   = 14;
  localparam int FCS_BYTES   = 4;
  localparam int LT_HI_IDX   = 12;
  localparam int LT_LO_IDX   = 13;
  localparam logic [15:0] TYPE_ID_MIN = 16'h0600;
  localparam int FIELD_W     = 16;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_PAD  = 2'd1,
    EM_DATA = 2'd2
  } emit_state_t;
endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  logic [W-1:0] slots [DEPTH];
  logic [PW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign rdata = slots[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) slots[wp[PW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_intake.sv
module rxf_intake #(
  parameter int AW    = 11,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_len_chk,
  input  logic             cfg_strip_fcs,
  input  logic             cfg_ign_fcs,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  input  logic [AW:0]      rel_ptr,
  input  logic             desc_full,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [7:0]       ram_wdata,
  output logic             desc_push,
  output logic [AW:0]      desc_start,
  output logic [AW:0]      desc_stored,
  output logic [AW:0]      desc_emit,
  output logic             commit,
  output logic             drop,
  output logic [CNT_W-1:0] len_err_cnt,
  output logic [CNT_W-1:0] fcs_err_cnt
);
  import rxf_pkg::*;

  localparam logic [AW:0] CAP   = (AW+1)'(1 << AW);
  localparam logic [AW:0] FCS_A = (AW+1)'(FCS_BYTES);
  localparam logic [FIELD_W-1:0] HDR_F  = FIELD_W'(HDR_BYTES);
  localparam logic [FIELD_W-1:0] OVH_F  = FIELD_W'(HDR_BYTES + FCS_BYTES);
  localparam logic [FIELD_W-1:0] FCS_F  = FIELD_W'(FCS_BYTES);

  logic              in_frame;
  logic [AW:0]       wr_ptr, fs_ptr;
  logic [FIELD_W-1:0] nbytes, lt_q;
  logic              ovf_q;

  logic              take;
  logic [AW:0]       base, fs_cur, used;
  logic              room, do_wr, ovf_n, end_fr, keep;
  logic [FIELD_W-1:0] idx, total, lt_n, lt_base, measured;
  logic              len_bad, crc_bad;
  logic [AW:0]       emit_len;

  always_comb begin
    take    = in_valid && (in_sof || in_frame);
    base    = (in_sof && in_frame) ? fs_ptr : wr_ptr;
    fs_cur  = in_sof ? base : fs_ptr;
    idx     = in_sof ? '0 : nbytes;
    total   = idx + 1'b1;
    used    = base - rel_ptr;
    room    = (used < CAP);
    do_wr   = take && !(in_sof ? 1'b0 : ovf_q) && room;
    ovf_n   = (in_sof ? 1'b0 : ovf_q) || (take && !room);
    lt_base = in_sof ? '0 : lt_q;
    lt_n    = lt_base;
    if (idx == FIELD_W'(LT_HI_IDX)) lt_n = {in_data, lt_base[7:0]};
    if (idx == FIELD_W'(LT_LO_IDX)) lt_n = {lt_base[15:8], in_data};
    measured = (total >= OVH_F) ? (total - OVH_F) : '0;
    len_bad  = cfg_len_chk && (total >= HDR_F) && (lt_n < TYPE_ID_MIN) &&
               (measured < lt_n);
    crc_bad  = !in_crc_ok;
    if (cfg_strip_fcs)
      emit_len = (total >= FCS_F) ? (total[AW:0] - FCS_A) : '0;
    else
      emit_len = total[AW:0];
    end_fr  = take && in_eof;
    keep    = !ovf_n && !len_bad && (!crc_bad || cfg_ign_fcs) &&
              (emit_len != '0) && !desc_full;
  end

  assign ram_we      = do_wr;
  assign ram_waddr   = base[AW-1:0];
  assign ram_wdata   = in_data;
  assign desc_push   = end_fr && keep;
  assign desc_start  = fs_cur;
  assign desc_stored = total[AW:0];
  assign desc_emit   = emit_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame    <= 1'b0;
      wr_ptr      <= '0;
      fs_ptr      <= '0;
      nbytes      <= '0;
      lt_q        <= '0;
      ovf_q       <= 1'b0;
      commit      <= 1'b0;
      drop        <= 1'b0;
      len_err_cnt <= '0;
      fcs_err_cnt <= '0;
    end else begin
      commit <= end_fr && keep;
      drop   <= end_fr && !keep;
      if (take) begin
        nbytes   <= total;
        lt_q     <= lt_n;
        ovf_q    <= ovf_n;
        in_frame <= !in_eof;
        if (in_sof) fs_ptr <= base;
        wr_ptr   <= (end_fr && !keep) ? fs_cur : (base + (AW+1)'(do_wr));
      end
      if (end_fr && !ovf_n && len_bad && (len_err_cnt != '1))
        len_err_cnt <= len_err_cnt + 1'b1;
      if (end_fr && !ovf_n && crc_bad && !cfg_ign_fcs && (fcs_err_cnt != '1))
        fcs_err_cnt <= fcs_err_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_emit.sv
module rxf_emit #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desc_empty,
  input  logic [AW:0]   desc_start,
  input  logic [AW:0]   desc_stored,
  input  logic [AW:0]   desc_emit,
  input  logic [1:0]    desc_offset,
  input  logic [7:0]    ram_rdata,
  output logic          desc_pop,
  output logic [AW-1:0] ram_raddr,
  output logic [AW:0]   rel_ptr,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_pad,
  output logic          out_sof,
  output logic          out_eof
);
  import rxf_pkg::*;

  localparam logic [AW:0] ONE_A = (AW+1)'(1);

  emit_state_t state;
  logic [AW:0] rd_ptr, left, end_ptr;
  logic [1:0]  pad_left;
  logic        first;

  logic slot_v, slot_pad, slot_sof, slot_eof;
  logic s1_v, s1_pad, s1_sof, s1_eof;

  always_comb begin
    slot_v   = 1'b0;
    slot_pad = 1'b0;
    slot_sof = 1'b0;
    slot_eof = 1'b0;
    desc_pop = 1'b0;
    case (state)
      EM_IDLE: desc_pop = !desc_empty;
      EM_PAD: begin
        slot_v   = 1'b1;
        slot_pad = 1'b1;
        slot_sof = first;
      end
      EM_DATA: begin
        slot_v   = 1'b1;
        slot_sof = first;
        slot_eof = (left == ONE_A);
      end
      default: ;
    endcase
  end

  assign ram_raddr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= EM_IDLE;
      rd_ptr   <= '0;
      left     <= '0;
      end_ptr  <= '0;
      pad_left <= '0;
      first    <= 1'b0;
      rel_ptr  <= '0;
    end else begin
      case (state)
        EM_IDLE: if (!desc_empty) begin
          rd_ptr   <= desc_start;
          left     <= desc_emit;
          end_ptr  <= desc_start + desc_stored;
          pad_left <= desc_offset;
          first    <= 1'b1;
          state    <= (desc_offset != 2'd0) ? EM_PAD : EM_DATA;
        end
        EM_PAD: begin
          first    <= 1'b0;
          pad_left <= pad_left - 1'b1;
          if (pad_left == 2'd1) state <= EM_DATA;
        end
        EM_DATA: begin
          first  <= 1'b0;
          rd_ptr <= rd_ptr + 1'b1;
          left   <= left - 1'b1;
          if (left == ONE_A) begin
            state   <= EM_IDLE;
            rel_ptr <= end_ptr;
          end
        end
        default: state <= EM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_pad <= 1'b0; s1_sof <= 1'b0; s1_eof <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_pad <= 1'b0;
      out_sof <= 1'b0; out_eof <= 1'b0;
    end else begin
      s1_v      <= slot_v;
      s1_pad    <= slot_pad;
      s1_sof    <= slot_sof;
      s1_eof    <= slot_eof;
      out_valid <= s1_v;
      out_data  <= (s1_v && !s1_pad) ? ram_rdata : 8'd0;
      out_pad   <= s1_v && s1_pad;
      out_sof   <= s1_v && s1_sof;
      out_eof   <= s1_v && s1_eof;
    end
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int DEPTH      = 2048,
  parameter int DESC_DEPTH = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_offset,
  input  logic             cfg_len_chk,
  input  logic             cfg_strip_fcs,
  input  logic             cfg_ign_fcs,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_ok,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_pad,
  output logic             out_sof,
  output logic             out_eof,
  output logic             frame_commit,
  output logic             frame_drop,
  output logic [CNT_W-1:0] len_err_cnt,
  output logic [CNT_W-1:0] fcs_err_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int DW = 2 + 3 * PW;

  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_rdata;
  logic          d_push, d_pop, d_full, d_empty;
  logic [AW:0]   w_start, w_stored, w_emit, rel_ptr;
  logic [DW-1:0] d_wdata, d_rdata;

  rxf_intake #(.AW(AW), .CNT_W(CNT_W)) u_intake (
    .clk(clk), .rst(rst),
    .cfg_len_chk(cfg_len_chk), .cfg_strip_fcs(cfg_strip_fcs),
    .cfg_ign_fcs(cfg_ign_fcs),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .in_crc_ok(in_crc_ok),
    .rel_ptr(rel_ptr), .desc_full(d_full),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .desc_push(d_push), .desc_start(w_start), .desc_stored(w_stored),
    .desc_emit(w_emit),
    .commit(frame_commit), .drop(frame_drop),
    .len_err_cnt(len_err_cnt), .fcs_err_cnt(fcs_err_cnt)
  );

  rxf_ram #(.AW(AW), .DW(8)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  assign d_wdata = {cfg_offset, w_start, w_stored, w_emit};

  rxf_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst(rst), .push(d_push), .wdata(d_wdata),
    .pop(d_pop), .rdata(d_rdata), .full(d_full), .empty(d_empty)
  );

  rxf_emit #(.AW(AW)) u_emit (
    .clk(clk), .rst(rst), .desc_empty(d_empty),
    .desc_start(d_rdata[3*PW-1:2*PW]),
    .desc_stored(d_rdata[2*PW-1:PW]),
    .desc_emit(d_rdata[PW-1:0]),
    .desc_offset(d_rdata[DW-1:3*PW]),
    .ram_rdata(ram_rdata), .desc_pop(d_pop), .ram_raddr(ram_raddr),
    .rel_ptr(rel_ptr),
    .out_valid(out_valid), .out_data(out_data), .out_pad(out_pad),
    .out_sof(out_sof), .out_eof(out_eof)
  );
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_len_chk,
  input logic             cfg_ign_fcs,
  input logic             in_valid,
  input logic             in_eof,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_pad,
  input logic             out_sof,
  input logic             frame_commit,
  input logic             frame_drop,
  input logic [CNT_W-1:0] len_err_cnt,
  input logic [CNT_W-1:0] fcs_err_cnt
);
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    !(frame_commit && frame_drop));

  p_no_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> $past(out_valid));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pad) |-> (out_data == 8'd0));

  p_pad_lead_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_pad && !out_sof) |-> $past(out_valid && out_pad));

  p_len_off_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && !cfg_len_chk) |=> $stable(len_err_cnt));

  p_fcs_ign_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof && cfg_ign_fcs) |=> $stable(fcs_err_cnt));

  p_len_step_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(len_err_cnt) || (len_err_cnt == $past(len_err_cnt) + 1'b1)));

  p_fcs_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (&fcs_err_cnt) |=> (&fcs_err_cnt));

  p_len_sat_r10: assert property (@(posedge clk) disable iff (rst)
    (&len_err_cnt) |=> (&len_err_cnt));
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_len_chk(cfg_len_chk), .cfg_ign_fcs(cfg_ign_fcs),
  .in_valid(in_valid), .in_eof(in_eof), .out_valid(out_valid),
  .out_data(out_data), .out_pad(out_pad), .out_sof(out_sof),
  .frame_commit(frame_commit), .frame_drop(frame_drop),
  .len_err_cnt(len_err_cnt), .fcs_err_cnt(fcs_err_cnt)
);

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  localparam int CW  = 3;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_offset = '0;
  logic cfg_len_chk = 0, cfg_strip_fcs = 0, cfg_ign_fcs = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_ok = 0;
  logic [7:0] in_data = '0;
  logic out_valid, out_pad, out_sof, out_eof, frame_commit, frame_drop;
  logic [7:0] out_data;
  logic [CW-1:0] len_err_cnt, fcs_err_cnt;

  always #4 clk = ~clk;

  rx_frame_filter #(.DEPTH(2048), .DESC_DEPTH(4), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .cfg_offset(cfg_offset), .cfg_len_chk(cfg_len_chk),
    .cfg_strip_fcs(cfg_strip_fcs), .cfg_ign_fcs(cfg_ign_fcs),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_ok(in_crc_ok), .out_valid(out_valid), .out_data(out_data),
    .out_pad(out_pad), .out_sof(out_sof), .out_eof(out_eof),
    .frame_commit(frame_commit), .frame_drop(frame_drop),
    .len_err_cnt(len_err_cnt), .fcs_err_cnt(fcs_err_cnt)
  );

  int nvec = 0, nfail = 0;
  int ncap = 0, ncommit = 0, ndrop = 0;
  int exp_len = 0, exp_fcs = 0;
  int frame_no = 0;
  logic [7:0] cap_d [128];
  logic       cap_p [128];
  logic       cap_s [128];
  logic       cap_e [128];
  bit done = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && ncap < 128) begin
        cap_d[ncap] = out_data; cap_p[ncap] = out_pad;
        cap_s[ncap] = out_sof;  cap_e[ncap] = out_eof;
        ncap++;
      end
      if (frame_commit) ncommit++;
      if (frame_drop)   ndrop++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s frame %0d: actual %0d expected %0d", tag, frame_no, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int fno, int i, logic [15:0] lt);
    if (i == 12) return lt[15:8];
    if (i == 13) return lt[7:0];
    return 8'((i * 13) + (fno * 5) + 1);
  endfunction

  task automatic run_frame(input int len, input logic [15:0] lt, input bit crc,
                           input int off, input bit lchk, input bit strip,
                           input bit ign, input string tag);
    int meas, emit, nout;
    bit lbad, keep;
    @(negedge clk);
    cfg_offset = 2'(off); cfg_len_chk = lchk; cfg_strip_fcs = strip;
    cfg_ign_fcs = ign;
    ncap = 0; ncommit = 0; ndrop = 0;
    for (int i = 0; i < len; i++) begin
      in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = byte_at(frame_no, i, lt); in_crc_ok = crc;
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_ok = 0;
    repeat (len + 12) @(negedge clk);
    meas = (len >= 18) ? len - 18 : 0;
    lbad = lchk && (len >= 14) && (lt < 16'h0600) && (meas < int'(lt));
    emit = strip ? ((len >= 4) ? len - 4 : 0) : len;
    keep = !lbad && (crc || ign) && (emit != 0);
    if (lbad && exp_len < SAT) exp_len++;
    if (!crc && !ign && exp_fcs < SAT) exp_fcs++;
    nout = keep ? off + emit : 0;
    chk({tag, " R2 commit"}, ncommit, keep ? 1 : 0);
    chk({tag, " R2 drop"}, ndrop, keep ? 0 : 1);
    chk({tag, " R2/R7 count"}, ncap, nout);
    if (ncap == nout) begin
      for (int k = 0; k < nout; k++) begin
        if (k < off) begin
          chk({tag, " R3 pad data"}, cap_d[k], 0);
          chk({tag, " R3 pad flag"}, cap_p[k], 1);
        end else begin
          chk({tag, " R2 data"}, cap_d[k], byte_at(frame_no, k - off, lt));
          chk({tag, " R3 data flag"}, cap_p[k], 0);
        end
        chk({tag, " R2 sof"}, cap_s[k], (k == 0) ? 1 : 0);
        chk({tag, " R2 eof"}, cap_e[k], (k == nout - 1) ? 1 : 0);
      end
    end
    chk({tag, " R4/R10 len_err_cnt"}, int'(len_err_cnt), exp_len);
    chk({tag, " R8/R10 fcs_err_cnt"}, int'(fcs_err_cnt), exp_fcs);
    frame_no++;
  endtask

  initial begin
    int lens [10] = '{1, 3, 4, 5, 14, 17, 18, 19, 30, 64};
    logic [15:0] lts [8] = '{16'd0, 16'd4, 16'd10, 16'd11, 16'd12,
                             16'h05FF, 16'h0600, 16'hFFFF};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 commit", frame_commit, 0);
    chk("R1 drop", frame_drop, 0);
    chk("R1 len_err_cnt", len_err_cnt, 0);
    chk("R1 fcs_err_cnt", fcs_err_cnt, 0);
    // R3 R7 R11: offset x strip x length sweep, type field, good CRC
    for (int o = 0; o < 4; o++)
      for (int s = 0; s < 2; s++)
        for (int l = 0; l < 10; l++)
          run_frame(lens[l], 16'h0800, 1'b1, o, 1'b0, s[0], 1'b0, "sweep R3 R7 R11");
    // R4 R5: length field around measured length and the 0x0600 limit
    for (int l = 17; l <= 30; l++)
      for (int t = 0; t < 8; t++)
        run_frame(l, lts[t], 1'b1, l % 4, 1'b1, 1'b1, 1'b0, "lencheck R4 R5");
    // R6: same short-field frames with the check off
    for (int l = 14; l <= 20; l++)
      run_frame(l, 16'd40, 1'b1, 1, 1'b0, 1'b0, 1'b0, "lenoff R6");
    // R8 R9: bad CRC with and without ignore mode
    for (int l = 5; l <= 24; l += 3) begin
      run_frame(l, 16'h0800, 1'b0, 2, 1'b0, 1'b1, 1'b1, "ignore R9");
      run_frame(l, 16'h0800, 1'b0, 3, 1'b0, 1'b0, 1'b0, "crcbad R8");
    end
    // R10: push the FCS counter past its ceiling
    for (int n = 0; n < 10; n++)
      run_frame(20, 16'h0800, 1'b0, 0, 1'b0, 1'b0, 1'b0, "saturate R10");
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++; nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule